// File: doc/BRIEF.md
# Serial Port Status Flag Controller

This block keeps the status flags of an asynchronous serial port and presents them as one 16-bit status word. The transmit and receive datapaths report events to it as single-cycle strobes: the transmit buffer byte moving into the shifter, the transmitter going fully idle, a received character landing in the receive buffer together with its error indications, a lost character, and an idle line. The receiver's busy indication arrives as a level.

A latched flag cannot be cleared by writing to it. Clearing takes two steps. First, a bus read of either byte of the status word arms every flag that is set at that moment. Second, the matching data-register access clears the armed flags. For the transmit flags, that access is a write to the data register. For the receive flags, it is a read of the data register. Each latched flag keeps its own arm bit. A new set event always takes priority over a pending clear, so no event is lost between the status read and the data access.

Top module: `ssf_status_ctrl`

## Requirements
- R1: Status word layout: bit 8 transmit-buffer-empty, bit 7 transmit-done, bit 6 receive-full, bit 5 receiver-busy, bit 4 line-idle, bit 3 overrun, bit 2 noise, bit 1 framing, bit 0 parity. Bits 15 to 9 always read zero. Bit 5 shows `rx_active_i` as registered one cycle earlier.
- R2: After reset the status word is 0x0180: transmit-buffer-empty and transmit-done set, all other bits clear.
- R3: `tx_load_i` sets bit 8 and `tx_done_i` sets bit 7. The new value is visible in the cycle after the strobe.
- R4: Bits 8 and 7 clear in the cycle after a `data_wr_i` pulse, and only if a status read taken while the bit was set came earlier.
- R5: `rx_load_i` sets bit 6. The noise, framing and parity inputs set bits 2, 1 and 0 in that same cycle when they accompany `rx_load_i`. Without `rx_load_i`, those error inputs have no effect.
- R6: Bits 6, 4, 3, 2, 1 and 0 clear in the cycle after a `data_rd_i` pulse, and only if they were armed by an earlier status read.
- R7: A pulse on either `stat_rd_hi_i` or `stat_rd_lo_i` arms every latched flag that is set at that moment.
- R8: A data access with no arming status read before it changes nothing. A data write never clears a receive flag, and a data read never clears a transmit flag.
- R9: When a set event and a clearing access for the same flag fall in the same cycle, the flag stays set and its arm is dropped. A following access with no new status read leaves the flag set.
- R10: A flag that was clear at the status read and becomes set afterwards is not cleared by the next data access.
- R11: `rx_idle_i` sets bit 4 and `rx_overrun_i` sets bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_load_i | input | 1 | Transmit buffer byte moved into the shifter |
| tx_done_i | input | 1 | Transmitter finished all data, idle and break frames |
| rx_load_i | input | 1 | Receive shifter moved into the receive buffer |
| rx_noise_i | input | 1 | Noise seen on the character being loaded |
| rx_frame_i | input | 1 | Framing error on the character being loaded |
| rx_parity_i | input | 1 | Parity error on the character being loaded |
| rx_overrun_i | input | 1 | A received character was lost |
| rx_idle_i | input | 1 | Idle line detected |
| rx_active_i | input | 1 | Receiver currently busy (level) |
| stat_rd_hi_i | input | 1 | Bus read of the upper status byte |
| stat_rd_lo_i | input | 1 | Bus read of the lower status byte |
| data_rd_i | input | 1 | Bus read of the data register |
| data_wr_i | input | 1 | Bus write of the data register |
| status_o | output | 16 | Status word |

## Verification
The bench targets a data access that arrives without an arming read. A design that ignored the arm would clear a flag software never saw. It also checks accesses of the wrong kind, which a design that merged the two clear groups would let clear flags. It covers a set event in the same cycle as a clear; getting that wrong loses a received character or an empty-buffer event. It also covers a flag that rises between the read and the access, which a design arming at access time would wrongly clear. A long pseudo-random sweep of all strobes against a flag-and-arm model exercises the combinations of these cases.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
    localparam int STATUS_W = 16;
    localparam int FLAG_W   = 9;

    localparam int BIT_PARITY  = 0;
    localparam int BIT_FRAMING = 1;
    localparam int BIT_NOISE   = 2;
    localparam int BIT_OVERRUN = 3;
    localparam int BIT_LINE_ID = 4;
    localparam int BIT_RX_BUSY = 5;
    localparam int BIT_RX_FULL = 6;
    localparam int BIT_TX_DONE = 7;
    localparam int BIT_TX_EMPTY = 8;

    localparam logic [FLAG_W-1:0] RESET_FLAGS = 9'h180;
    // flags that a data-register write completes the clear of
    localparam logic [FLAG_W-1:0] WR_CLR_MASK = 9'h180;
    // flags that a data-register read completes the clear of
    localparam logic [FLAG_W-1:0] RD_CLR_MASK = 9'h05F;
    // bits that mirror a level instead of latching an event
    localparam logic [FLAG_W-1:0] LEVEL_MASK  = 9'h020;

    typedef struct packed {
        logic flag;
        logic armed;
    } cell_state_t;
endpackage

// File: rtl/ssf_flag_cell.sv
module ssf_flag_cell
    import ssf_pkg::*;
#(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic arm_i,
    input  logic clr_i,
    output logic flag_o
);
    cell_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i) begin
            st_d.flag  = 1'b1;
            st_d.armed = 1'b0;
        end else if (clr_i) begin
            if (st_q.armed) begin
                st_d.flag = 1'b0;
            end
            st_d.armed = 1'b0;
        end else if (arm_i) begin
            st_d.armed = st_q.flag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{flag: RESET_VAL, armed: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/ssf_event_map.sv
module ssf_event_map
    import ssf_pkg::*;
(
    input  logic              tx_load_i,
    input  logic              tx_done_i,
    input  logic              rx_load_i,
    input  logic              rx_noise_i,
    input  logic              rx_frame_i,
    input  logic              rx_parity_i,
    input  logic              rx_overrun_i,
    input  logic              rx_idle_i,
    input  logic              rx_active_i,
    input  logic              stat_rd_hi_i,
    input  logic              stat_rd_lo_i,
    input  logic              data_rd_i,
    input  logic              data_wr_i,
    output logic [FLAG_W-1:0] set_vec_o,
    output logic [FLAG_W-1:0] clr_vec_o,
    output logic              arm_o
);
    always_comb begin
        set_vec_o               = '0;
        set_vec_o[BIT_TX_EMPTY] = tx_load_i;
        set_vec_o[BIT_TX_DONE]  = tx_done_i;
        set_vec_o[BIT_RX_FULL]  = rx_load_i;
        set_vec_o[BIT_RX_BUSY]  = rx_active_i;
        set_vec_o[BIT_LINE_ID]  = rx_idle_i;
        set_vec_o[BIT_OVERRUN]  = rx_overrun_i;
        set_vec_o[BIT_NOISE]    = rx_load_i & rx_noise_i;
        set_vec_o[BIT_FRAMING]  = rx_load_i & rx_frame_i;
        set_vec_o[BIT_PARITY]   = rx_load_i & rx_parity_i;
    end

    // either byte of the status word counts as a full read
    assign arm_o = stat_rd_hi_i | stat_rd_lo_i;

    for (genvar i = 0; i < FLAG_W; i++) begin : g_clr
        if (WR_CLR_MASK[i]) begin : g_wr
            assign clr_vec_o[i] = data_wr_i;
        end else if (RD_CLR_MASK[i]) begin : g_rd
            assign clr_vec_o[i] = data_rd_i;
        end else begin : g_none
            assign clr_vec_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/ssf_status_ctrl.sv
module ssf_status_ctrl
    import ssf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_load_i,
    input  logic                tx_done_i,
    input  logic                rx_load_i,
    input  logic                rx_noise_i,
    input  logic                rx_frame_i,
    input  logic                rx_parity_i,
    input  logic                rx_overrun_i,
    input  logic                rx_idle_i,
    input  logic                rx_active_i,
    input  logic                stat_rd_hi_i,
    input  logic                stat_rd_lo_i,
    input  logic                data_rd_i,
    input  logic                data_wr_i,
    output logic [STATUS_W-1:0] status_o
);
    localparam int PAD_W = STATUS_W - FLAG_W;

    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] clr_vec;
    logic              arm;
    logic [FLAG_W-1:0] flags;

    ssf_event_map u_map (
        .tx_load_i    (tx_load_i),
        .tx_done_i    (tx_done_i),
        .rx_load_i    (rx_load_i),
        .rx_noise_i   (rx_noise_i),
        .rx_frame_i   (rx_frame_i),
        .rx_parity_i  (rx_parity_i),
        .rx_overrun_i (rx_overrun_i),
        .rx_idle_i    (rx_idle_i),
        .rx_active_i  (rx_active_i),
        .stat_rd_hi_i (stat_rd_hi_i),
        .stat_rd_lo_i (stat_rd_lo_i),
        .data_rd_i    (data_rd_i),
        .data_wr_i    (data_wr_i),
        .set_vec_o    (set_vec),
        .clr_vec_o    (clr_vec),
        .arm_o        (arm)
    );

    for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
        if (LEVEL_MASK[i]) begin : g_level
            logic lvl_d, lvl_q;
            always_comb lvl_d = set_vec[i];
            always_ff @(posedge clk) begin
                if (!rst_n) lvl_q <= RESET_FLAGS[i];
                else        lvl_q <= lvl_d;
            end
            assign flags[i] = lvl_q;
        end else begin : g_latch
            ssf_flag_cell #(.RESET_VAL(RESET_FLAGS[i])) u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (set_vec[i]),
                .arm_i  (arm),
                .clr_i  (clr_vec[i]),
                .flag_o (flags[i])
            );
        end
    end

    assign status_o = {{PAD_W{1'b0}}, flags};
endmodule

// File: rtl/ssf_status_chk.sv
module ssf_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tx_load_i,
    input logic        tx_done_i,
    input logic        rx_load_i,
    input logic        rx_noise_i,
    input logic        rx_active_i,
    input logic        data_rd_i,
    input logic        data_wr_i,
    input logic [15:0] status_o
);
    AST_RESET_VALUE: assert property (@(posedge clk)
        !rst_n |=> status_o == 16'h0180); // R2
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[15:9] == 7'd0); // R1
    AST_BUSY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_active_i |=> status_o[5]); // R1
    AST_TX_EMPTY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_i |=> status_o[8]); // R3
    AST_TX_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_i |=> status_o[7]); // R3
    AST_TX_FALL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[8]) |-> $past(data_wr_i)); // R4
    AST_NOISE_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[2]) |-> ($past(rx_load_i) && status_o[6])); // R5
    AST_NOISE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_load_i && rx_noise_i) |=> status_o[2]); // R5
    AST_RX_FALL_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[6]) |-> $past(data_rd_i)); // R6
    AST_RX_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_load_i && data_rd_i) |=> status_o[6]); // R9
endmodule

bind ssf_status_ctrl ssf_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_load_i   (tx_load_i),
    .tx_done_i   (tx_done_i),
    .rx_load_i   (rx_load_i),
    .rx_noise_i  (rx_noise_i),
    .rx_active_i (rx_active_i),
    .data_rd_i   (data_rd_i),
    .data_wr_i   (data_wr_i),
    .status_o    (status_o)
);

// File: tb/ssf_status_ctrl_bench.sv
module ssf_status_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SWEEP_N    = 4000;
    localparam int WATCHDOG   = 100000;

    // stimulus vector bit positions
    localparam int V_TXL = 0, V_TXD = 1, V_RXL = 2, V_NOI = 3, V_FRM = 4,
                   V_PAR = 5, V_OVR = 6, V_IDL = 7, V_ACT = 8, V_RDH = 9,
                   V_RDL = 10, V_DRD = 11, V_DWR = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] vin = '0;
    logic [15:0] status;
    int          n_checks = 0;
    int          n_fail = 0;
    int          cycles = 0;
    logic        done = 1'b0;

    // bench model of flags (bits 8..0) and arms
    logic [8:0] mflag = 9'h180;
    logic [8:0] marm  = 9'h000;

    always #(CLK_PERIOD/2) clk = ~clk;

    ssf_status_ctrl u_ssf_status_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_load_i    (vin[V_TXL]),
        .tx_done_i    (vin[V_TXD]),
        .rx_load_i    (vin[V_RXL]),
        .rx_noise_i   (vin[V_NOI]),
        .rx_frame_i   (vin[V_FRM]),
        .rx_parity_i  (vin[V_PAR]),
        .rx_overrun_i (vin[V_OVR]),
        .rx_idle_i    (vin[V_IDL]),
        .rx_active_i  (vin[V_ACT]),
        .stat_rd_hi_i (vin[V_RDH]),
        .stat_rd_lo_i (vin[V_RDL]),
        .data_rd_i    (vin[V_DRD]),
        .data_wr_i    (vin[V_DWR]),
        .status_o     (status)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: status actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic model_step(input logic [12:0] v);
        logic [8:0] setv, clrv;
        logic       rd;
        setv = {v[V_TXL], v[V_TXD], v[V_RXL], 1'b0, v[V_IDL], v[V_OVR],
                v[V_RXL] & v[V_NOI], v[V_RXL] & v[V_FRM], v[V_RXL] & v[V_PAR]};
        clrv = {v[V_DWR], v[V_DWR], v[V_DRD], 1'b0, {5{v[V_DRD]}}};
        rd   = v[V_RDH] | v[V_RDL];
        for (int i = 0; i < 9; i++) begin
            if (i == 5) begin
                mflag[i] = v[V_ACT];
            end else if (setv[i]) begin
                mflag[i] = 1'b1; marm[i] = 1'b0;
            end else if (clrv[i]) begin
                if (marm[i]) mflag[i] = 1'b0;
                marm[i] = 1'b0;
            end else if (rd) begin
                marm[i] = mflag[i];
            end
        end
    endtask

    // one cycle: drive, let the edge pass, compare to model
    task automatic apply(input logic [12:0] v, input string tag);
        @(negedge clk);
        vin = v;
        @(posedge clk);
        #1;
        model_step(v);
        check(status, {7'd0, mflag}, tag);
        @(negedge clk);
        vin = '0;
    endtask

    function automatic logic [12:0] b(input int p);
        return 13'(1) << p;
    endfunction

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        #1;
        check(status, 16'h0180, "R2 reset value");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(status, 16'h0180, "R2 after reset release");

        apply(b(V_DWR), "R8 write without read");
        check(status, 16'h0180, "R8 unarmed write keeps flags");
        apply(b(V_RDL), "R7 low byte read");
        apply(b(V_DWR), "R4 write clears tx flags");
        check(status, 16'h0000, "R4 tx flags cleared");
        apply(b(V_TXL), "R3 buffer empty");
        check(status, 16'h0100, "R3 buffer empty set");
        apply(b(V_TXD), "R3 tx done");
        check(status, 16'h0180, "R3 tx done set");
        apply(b(V_RXL) | b(V_NOI) | b(V_PAR), "R5 load with errors");
        check(status, 16'h01C5, "R5 errors with full");
        apply(b(V_FRM), "R5 error without load");
        check(status, 16'h01C5, "R5 lone error ignored");
        apply(b(V_RDH), "R7 high byte read");
        apply(b(V_DWR), "R8 write vs rx flags");
        check(status, 16'h0045, "R8 write keeps rx flags");
        apply(b(V_DRD), "R6 read clears rx flags");
        check(status, 16'h0000, "R6 rx flags cleared");
        apply(b(V_OVR) | b(V_IDL), "R11 overrun and idle");
        check(status, 16'h0018, "R11 overrun and idle set");
        apply(b(V_RDL), "R10 arm read");
        apply(b(V_RXL), "R10 late set");
        apply(b(V_DRD), "R10 access");
        check(status, 16'h0040, "R10 late flag kept");
        apply(b(V_RDL), "R9 arm read");
        apply(b(V_RXL) | b(V_DRD), "R9 set with clear");
        check(status, 16'h0040, "R9 set wins");
        apply(b(V_DRD), "R9 second access");
        check(status, 16'h0040, "R9 arm dropped");
        apply(b(V_ACT), "R1 busy level");
        check(status, 16'h0060, "R1 busy shown");
        apply(13'd0, "R1 busy drop");
        check(status, 16'h0040, "R1 busy cleared");

        lfsr = 32'h1D87_2A5F;
        for (int n = 0; n < SWEEP_N; n++) begin
            logic [12:0] v;
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            v = lfsr[12:0];
            v[V_TXL] = lfsr[0] & lfsr[16];
            v[V_TXD] = lfsr[1] & lfsr[17];
            v[V_RXL] = lfsr[2] & lfsr[18];
            v[V_OVR] = lfsr[6] & lfsr[22];
            v[V_IDL] = lfsr[7] & lfsr[23];
            v[V_RDH] = lfsr[9] & lfsr[25] & lfsr[26];
            v[V_RDL] = lfsr[10] & lfsr[27];
            v[V_DRD] = lfsr[11] & lfsr[28];
            v[V_DWR] = lfsr[12] & lfsr[29];
            apply(v, "R1 R3 R4 R5 R6 R7 R8 R9 R10 R11 sweep");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: cycles actual %0d expected below %0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule